// File: doc/BRIEF.md
# USB Device Port Status and Control Register

This block holds the 32-bit status and control word of one device-side USB port. Each field has its own write rule. Connect status and device speed follow the link layer and cannot be written from the bus. The link-state field changes only when a bus write carries the link-state write strobe, or when the link layer reports a new state. Four change and enable flags are cleared by writing 1. The two wake-enable bits are ordinary read/write storage.

The link-layer model drives the following inputs:
- the connect level,
- the negotiated speed,
- the port-reset signalling level,
- a pulse that enables the port,
- link-state reports.

The block turns these into sticky change flags. It also drives one port-change summary output, which a controller status register can use as its port-change-detect bit.

The link state is held by a small state machine whose states are the link power states:
- U0, U1, U2 and U3
- Disabled, RxDetect, Inactive, Polling, Recovery, HotReset, Compliance, Test and Resume
- the three reserved codes 12, 13 and 14

It has three named transitions:
- **hold**: no update in the cycle.
- **hw_report**: the link layer reports a state. This has priority.
- **sw_strobe**: a bus write with the strobe bit set.

The link-change flag is raised when the state moves along one of the qualifying transitions.

Top module: `port_ctl_reg`

## Requirements
- R1: Bit 0 shows the connect input as sampled at the previous clock edge. Bus writes never change it.
- R2: Bits 13:10 show the speed input as sampled at the previous clock edge. The codes are 0 undefined, 1 full, 3 high, 4 super and 5 super-plus, and the other codes are reserved. Bus writes never change this field.
- R3: Bits 8:5 hold the link state, coded U0=0, U1=1, U2=2, U3=3, Disabled=4, RxDetect=5, Inactive=6, Polling=7, Recovery=8, HotReset=9, Compliance=10, Test=11, Resume=15. A link-layer report (`lnk_state_vld`) loads the reported code at the next edge. In the same cycle it wins over a strobed bus write.
- R4: A bus write loads bits 8:5 only if bit 16 of the same write is 1. Bit 16 always reads 0.
- R5: Bits 1, 17, 21 and 22 are cleared by a bus write with a 1 in that position. A 0 there leaves them unchanged. If a set event occurs in the same cycle as the clear, the set wins.
- R6: Bit 4 shows the port-reset input as sampled at the previous edge. Bit 21 (reset change) sets when that input goes from 1 to 0.
- R7: Bit 22 (link change) sets only on these link-state moves:
  - U3 to Resume
  - Resume to U0
  - U3 to U0
  - U2 to U0
  - any other state to Inactive

  This applies whether the move comes from a report or from a strobed write. No other move sets it.
- R8: Bit 17 (connect change) sets whenever the connect input differs from the sampled connect status.
- R9: Bits 25 and 26 (wake on connect, wake on disconnect) take the value of every bus write. All bits not named in R1–R9 read 0.
- R10: `port_change` is 1 exactly when at least one of bits 17, 21 or 22 is 1.
- R11: During and after reset the word reads with link state RxDetect (5) and every other bit 0.
- R12: Bit 1 (enabled) sets one edge after a pulse on `lnk_enable_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write enable for this word |
| wr_data | input | 32 | Bus write data |
| rd_data | output | 32 | Current register word |
| lnk_connect | input | 1 | Connect level from the link layer |
| lnk_speed | input | 4 | Negotiated speed code |
| lnk_port_reset | input | 1 | Port-reset signalling level |
| lnk_enable_set | input | 1 | Pulse: the port became enabled |
| lnk_state_vld | input | 1 | A link-state report is valid this cycle |
| lnk_state | input | 4 | Reported link-state code |
| port_change | output | 1 | OR of the three change flags |

## Verification
The embedded properties check the following on every cycle:
- the connect and speed mirrors,
- the hold rule of the link-state machine when neither source updates it,
- the priority of link-layer reports over strobed writes,
- the clear and set-wins behaviour of each flag,
- the reset-change and connect-change set conditions,
- the U3-to-U0 link-change case.

The complete qualifying-transition table is exercised only by the bench, which sweeps all 256 from/to pairs of link-state codes. The bench scenarios also cover the following, none of which a single property states:
- that bus writes leave the read-only fields intact,
- that the strobe bit reads 0,
- that reserved bits read 0,
- that the wake bits behave as plain storage.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [3:0] {
        LS_U0         = 4'd0,
        LS_U1         = 4'd1,
        LS_U2         = 4'd2,
        LS_U3         = 4'd3,
        LS_DISABLED   = 4'd4,
        LS_RXDETECT   = 4'd5,
        LS_INACTIVE   = 4'd6,
        LS_POLLING    = 4'd7,
        LS_RECOVERY   = 4'd8,
        LS_HOTRESET   = 4'd9,
        LS_COMPLIANCE = 4'd10,
        LS_TEST       = 4'd11,
        LS_RSVD12     = 4'd12,
        LS_RSVD13     = 4'd13,
        LS_RSVD14     = 4'd14,
        LS_RESUME     = 4'd15
    } link_st_e;

    // Field positions inside the word (decoded by software, so fixed).
    localparam int B_CONN    = 0;
    localparam int B_ENA     = 1;
    localparam int B_PRST    = 4;
    localparam int B_LS_LO   = 5;
    localparam int B_STROBE  = 16;
    localparam int B_SPD_LO  = 10;
    localparam int B_CCHG    = 17;
    localparam int B_RCHG    = 21;
    localparam int B_LCHG    = 22;
    localparam int B_WK_CON  = 25;
    localparam int B_WK_DIS  = 26;

    // Qualifying moves for the link-change flag.
    function automatic logic plc_trigger(input link_st_e from_s, input link_st_e to_s);
        logic hit;
        hit = 1'b0;
        if (from_s == LS_U3     && to_s == LS_RESUME) hit = 1'b1;
        if (from_s == LS_RESUME && to_s == LS_U0)     hit = 1'b1;
        if (from_s == LS_U3     && to_s == LS_U0)     hit = 1'b1;
        if (from_s == LS_U2     && to_s == LS_U0)     hit = 1'b1;
        if (from_s != LS_INACTIVE && to_s == LS_INACTIVE) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/psc_link_fsm.sv
module psc_link_fsm
    import psc_pkg::*;
#(
    parameter int       LS_W      = 4,
    parameter link_st_e RST_STATE = LS_RXDETECT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_vld,
    input  logic [LS_W-1:0] hw_state,
    input  logic            sw_vld,
    input  logic [LS_W-1:0] sw_state,
    output link_st_e        state_o,
    output logic            plc_evt_o
);

    link_st_e st_q;
    link_st_e st_d;

    // Next-state selection: hold, hw_report (priority), sw_strobe.
    always_comb begin
        st_d = st_q;
        unique case ({hw_vld, sw_vld})
            2'b00:        st_d = st_q;
            2'b01:        st_d = link_st_e'(sw_state);
            2'b10, 2'b11: st_d = link_st_e'(hw_state);
            default:      st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    always_comb begin
        state_o   = st_q;
        plc_evt_o = (st_d != st_q) && plc_trigger(st_q, st_d);
    end

    // R4: without any update source the state holds.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_vld && !sw_vld) |=> $stable(st_q));

    // R3: a link-layer report is loaded even against a strobed write.
    a_r3_hw_priority: assert property (@(posedge clk) disable iff (!rst_n)
        hw_vld |=> (st_q == link_st_e'($past(hw_state))));

endmodule

// File: rtl/psc_chg_bit.sv
module psc_chg_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    logic q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign q_o = q;

    // R5: a write of 1 without a competing set clears the flag.
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

    // R5: a set event always leaves the flag at 1.
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R5: with neither set nor clear the flag keeps its value.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/port_ctl_reg.sv
module port_ctl_reg
    import psc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LS_W  = 4,
    parameter int SPD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    input  logic             lnk_connect,
    input  logic [SPD_W-1:0] lnk_speed,
    input  logic             lnk_port_reset,
    input  logic             lnk_enable_set,
    input  logic             lnk_state_vld,
    input  logic [LS_W-1:0]  lnk_state,
    output logic             port_change
);

    localparam int N_FLG = 4;
    localparam int FI_ENA = 0;
    localparam int FI_CCHG = 1;
    localparam int FI_RCHG = 2;
    localparam int FI_LCHG = 3;
    localparam int FLG_POS [N_FLG] = '{B_ENA, B_CCHG, B_RCHG, B_LCHG};

    // Sampled link-layer inputs.
    logic             con_q;
    logic [SPD_W-1:0] spd_q;
    logic             prst_q;
    logic [1:0]       wk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            con_q  <= 1'b0;
            spd_q  <= '0;
            prst_q <= 1'b0;
        end else begin
            con_q  <= lnk_connect;
            spd_q  <= lnk_speed;
            prst_q <= lnk_port_reset;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wk_q <= 2'b00;
        else if (wr_en) wk_q <= {wr_data[B_WK_DIS], wr_data[B_WK_CON]};
    end

    // Link-state machine.
    link_st_e ls_cur;
    logic     plc_evt;
    logic     sw_ls_vld;

    assign sw_ls_vld = wr_en && wr_data[B_STROBE];

    psc_link_fsm #(
        .LS_W      (LS_W),
        .RST_STATE (LS_RXDETECT)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_vld    (lnk_state_vld),
        .hw_state  (lnk_state),
        .sw_vld    (sw_ls_vld),
        .sw_state  (wr_data[B_LS_LO +: LS_W]),
        .state_o   (ls_cur),
        .plc_evt_o (plc_evt)
    );

    // Change and enable flags: write-1-to-clear with set priority.
    logic [N_FLG-1:0] flg_set;
    logic [N_FLG-1:0] flg_clr;
    logic [N_FLG-1:0] flg_q;

    always_comb begin
        flg_set          = '0;
        flg_set[FI_ENA]  = lnk_enable_set;
        flg_set[FI_CCHG] = (lnk_connect != con_q);
        flg_set[FI_RCHG] = prst_q && !lnk_port_reset;
        flg_set[FI_LCHG] = plc_evt;
    end

    for (genvar g = 0; g < N_FLG; g++) begin : g_flag
        assign flg_clr[g] = wr_en && wr_data[FLG_POS[g]];
        psc_chg_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flg_set[g]),
            .clr_i (flg_clr[g]),
            .q_o   (flg_q[g])
        );
    end

    // Read word assembly.
    always_comb begin
        rd_data                         = '0;
        rd_data[B_CONN]                 = con_q;
        rd_data[B_ENA]                  = flg_q[FI_ENA];
        rd_data[B_PRST]                 = prst_q;
        rd_data[B_LS_LO +: LS_W]        = LS_W'(ls_cur);
        rd_data[B_SPD_LO +: SPD_W]      = spd_q;
        rd_data[B_CCHG]                 = flg_q[FI_CCHG];
        rd_data[B_RCHG]                 = flg_q[FI_RCHG];
        rd_data[B_LCHG]                 = flg_q[FI_LCHG];
        rd_data[B_WK_CON]               = wk_q[0];
        rd_data[B_WK_DIS]               = wk_q[1];
    end

    assign port_change = flg_q[FI_CCHG] | flg_q[FI_RCHG] | flg_q[FI_LCHG];

    // Write bits that have no field.
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[DW-1:27], wr_data[24:23], wr_data[20:18],
                              wr_data[15:9], wr_data[4:2], wr_data[0]};

    // R1: connect bit mirrors the input of the previous cycle.
    a_r1_connect_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_data[B_CONN] == $past(lnk_connect)));

    // R2: speed field mirrors the input of the previous cycle.
    a_r2_speed_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_data[B_SPD_LO +: SPD_W] == $past(lnk_speed)));

    // R6: falling port-reset input raises reset change.
    a_r6_reset_change: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_q && !lnk_port_reset) |=> rd_data[B_RCHG]);

    // R8: connect input differing from the sampled status raises connect change.
    a_r8_connect_change: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_connect != con_q) |=> rd_data[B_CCHG]);

    // R7: a U3-to-U0 move always leaves link change set.
    a_r7_u3_to_u0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_data[B_LS_LO +: LS_W]) == 4'd3 && rd_data[B_LS_LO +: LS_W] == 4'd0)
        |-> rd_data[B_LCHG]);

    // R10: a newly raised link change shows on the summary.
    a_r10_summary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[B_LCHG]) |-> port_change);

endmodule

// File: tb/port_ctl_reg_bench.sv
`timescale 1ns/1ps
module port_ctl_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        lnk_connect = 1'b0;
    logic [3:0]  lnk_speed = '0;
    logic        lnk_port_reset = 1'b0;
    logic        lnk_enable_set = 1'b0;
    logic        lnk_state_vld = 1'b0;
    logic [3:0]  lnk_state = '0;
    logic        port_change;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    port_ctl_reg u_port_ctl_reg (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .lnk_connect    (lnk_connect),
        .lnk_speed      (lnk_speed),
        .lnk_port_reset (lnk_port_reset),
        .lnk_enable_set (lnk_enable_set),
        .lnk_state_vld  (lnk_state_vld),
        .lnk_state      (lnk_state),
        .port_change    (port_change)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic report(input logic [3:0] s);
        lnk_state_vld = 1'b1; lnk_state = s;
        tick();
        lnk_state_vld = 1'b0;
    endtask

    function automatic logic exp_plc(input logic [3:0] a, input logic [3:0] b);
        return (a == 4'd3 && b == 4'd15) || (a == 4'd15 && b == 4'd0) ||
               (a == 4'd3 && b == 4'd0)  || (a == 4'd2 && b == 4'd0)  ||
               (a != 4'd6 && b == 4'd6);
    endfunction

    localparam logic [31:0] USED_MASK = 32'h0662_3DF3;

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        // R11: reset value
        chk("R11 reset word", rd_data, 32'h0000_00A0);
        chk("R11 reset summary", {31'd0, port_change}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R11 after release", rd_data, 32'h0000_00A0);

        // R8 connect change, R5 write-0 no effect, R10 summary
        lnk_connect = 1'b1;
        tick();
        chk("R1 connect", {31'd0, rd_data[0]}, 32'd1);
        chk("R8 connect change", {31'd0, rd_data[17]}, 32'd1);
        chk("R10 summary on", {31'd0, port_change}, 32'd1);
        bus_write(32'h0);
        chk("R5 write 0 keeps", {31'd0, rd_data[17]}, 32'd1);
        bus_write(32'h1 << 17);
        chk("R5 write 1 clears", {31'd0, rd_data[17]}, 32'd0);
        chk("R10 summary off", {31'd0, port_change}, 32'd0);

        // R2/R1 sweep all speed codes, writes ignored
        for (int s = 0; s < 16; s++) begin
            lnk_speed = 4'(s);
            tick();
            chk("R2 speed mirror", {28'd0, rd_data[13:10]}, 32'(s));
            bus_write({18'd0, ~4'(s), 10'd0});
            chk("R2 speed write ignored", {28'd0, rd_data[13:10]}, 32'(s));
            chk("R1 connect write ignored", {31'd0, rd_data[0]}, 32'd1);
        end
        lnk_speed = 4'd4;
        tick();

        // R4 strobe gating
        bus_write(32'h0);
        chk("R4 no strobe keeps", {28'd0, rd_data[8:5]}, 32'd5);
        bus_write((32'h1 << 16) | (32'd1 << 5));
        chk("R4 strobe loads", {28'd0, rd_data[8:5]}, 32'd1);
        chk("R4 strobe reads 0", {31'd0, rd_data[16]}, 32'd0);
        chk("R7 RxDetect->U1 no flag", {31'd0, rd_data[22]}, 32'd0);

        // R3 priority of report over strobed write
        lnk_state_vld = 1'b1; lnk_state = 4'd2;
        wr_en = 1'b1; wr_data = (32'h1 << 16) | (32'd3 << 5);
        tick();
        lnk_state_vld = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R3 report wins", {28'd0, rd_data[8:5]}, 32'd2);

        // R7 exhaustive from/to sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                report(4'(a));
                bus_write(32'h1 << 22);
                report(4'(b));
                chk("R3 state loaded", {28'd0, rd_data[8:5]}, 32'(b));
                chk("R7 link change", {31'd0, rd_data[22]}, {31'd0, exp_plc(4'(a), 4'(b))});
                chk("R10 summary", {31'd0, port_change}, {31'd0, exp_plc(4'(a), 4'(b))});
            end
        end

        // R7 via strobed write: U3 -> U0
        report(4'd3);
        bus_write(32'h1 << 22);
        bus_write(32'h1 << 16);
        chk("R7 sw U3->U0", {31'd0, rd_data[22]}, 32'd1);
        bus_write(32'h1 << 22);

        // R5 set wins over clear
        lnk_connect = 1'b0;
        wr_en = 1'b1; wr_data = 32'h1 << 17;
        tick();
        wr_en = 1'b0; wr_data = '0;
        chk("R5 set wins", {31'd0, rd_data[17]}, 32'd1);
        bus_write(32'h1 << 17);

        // R12 enable pulse, R5 clear
        lnk_enable_set = 1'b1;
        tick();
        lnk_enable_set = 1'b0;
        chk("R12 enabled set", {31'd0, rd_data[1]}, 32'd1);
        chk("R10 enable not in summary", {31'd0, port_change}, 32'd0);
        bus_write(32'h0);
        chk("R5 enabled kept", {31'd0, rd_data[1]}, 32'd1);
        bus_write(32'h2);
        chk("R5 enabled cleared", {31'd0, rd_data[1]}, 32'd0);

        // R6 reset change
        lnk_port_reset = 1'b1;
        tick();
        chk("R6 reset level", {31'd0, rd_data[4]}, 32'd1);
        chk("R6 no change on rise", {31'd0, rd_data[21]}, 32'd0);
        lnk_port_reset = 1'b0;
        tick();
        chk("R6 reset level low", {31'd0, rd_data[4]}, 32'd0);
        tick();
        chk("R6 change on fall", {31'd0, rd_data[21]}, 32'd1);
        chk("R10 summary reset", {31'd0, port_change}, 32'd1);
        bus_write(32'h1 << 21);
        chk("R5 reset change cleared", {31'd0, rd_data[21]}, 32'd0);

        // R9 wake bits and reserved bits
        bus_write((32'h1 << 25) | (32'h1 << 26));
        chk("R9 wake both", {30'd0, rd_data[26:25]}, 32'd3);
        bus_write(32'h1 << 25);
        chk("R9 wake connect only", {30'd0, rd_data[26:25]}, 32'd1);
        bus_write(32'hFFFF_FFFF);
        chk("R9 reserved read 0", rd_data & ~USED_MASK, 32'd0);
        chk("R4 all-ones loads Resume", {28'd0, rd_data[8:5]}, 32'd15);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule